// File: doc/BRIEF.md
# Buffered SPI Command Sequencer

This block runs one SPI transaction at a time from a 512-byte buffer. A host fills the buffer over a simple byte-wide write port. The first two buffer bytes form a big-endian header that gives an opcode, a dual-data flag and a payload byte count. Up to 15 prepend bytes and the transmit payload follow the header. A command strobe starts the engine at once or arms it for an external trigger. It can also halt or flush the engine. The same command picks a timing profile, which is passed on to the bit-clock logic, and one of the chip-select lines.

The bit clock is generated outside the block and arrives as a single-cycle `bitTick` enable. Each tick completes one bit position: the block samples `sdi` and advances `sdo`. Prepend bytes always go out on one line. Payload bytes can switch to two data lines from a programmed byte offset. Received payload bytes are written back from buffer offset 0, over the header. The host can then read them back over the same port.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: Buffer byte 0 is the header's high byte. Header bits 15:13 are the opcode (0 sleep, 1 full duplex, 2 write only, 3 read only, 4 raise interrupt). Bit 11 requests dual data. Bits 10:0 are the payload byte count.
- R2: `cmdCode` 1 (start now), written while idle, decodes the header on that clock edge. `busy` is high from the next cycle until the transaction ends. `done` is high in the last busy cycle only, and `busy` is low in the cycle that follows.
- R3: Transmitted byte k of a transaction (prepend bytes included, counted from 0) comes from buffer address 2+k. It goes out MSB first. A single-line byte takes 8 ticks, drives `sdo[0]` with `sdoEn`=01, and samples `sdi[0]`.
- R4: The first `prependCnt` bytes (0 to 15) always use one line, whatever the dual settings. The payload follows them from address 2+`prependCnt`.
- R5: In a read-only transaction, every payload byte transmits 0xFF. Payload byte j received (j from 0) is stored at buffer address j.
- R6: In a full-duplex transaction, payload bytes are sent from the buffer and received payload bytes are stored from address 0 in the same pass.
- R7: A byte uses two lines when all of these hold: header bit 11 is set, the byte is a payload byte, and either the opcode is write with `dualWrEn` set and k ≥ `dualWrStart`, or the opcode is read with `dualRdEn` set and k ≥ `dualRdStart`. A dual byte takes 4 ticks. `sdo[1]`/`sdi[1]` carry the higher bit of each pair. A dual write drives `sdoEn`=11, and a dual read drives `sdoEn`=00.
- R8: Chip-select line i sits at its active level `csPolarity[i]` only while the line selected by `cmdSelect` is shifting data. At all other times it sits at `~csPolarity[i]`. At most one line is active.
- R9: A start command (code 1 or 2) issued while busy has no effect on the transaction and sets `ctrlInvalid`. The next accepted start clears it.
- R10: Halt (code 3) during shifting ends the transaction at the next byte boundary with no `done`. Flush (code 4) drops `busy` in the next cycle.
- R11: Code 2 arms the engine. `busy` is high but chip selects stay inactive and ticks are ignored until `extTrig` starts the transaction.
- R12: A sleep opcode keeps the block busy for `count` ticks with no chip select, then signals `done`. A raise-interrupt opcode signals `done` in the first cycle after the start.
- R13: Host writes while busy are ignored. `hostRData` returns the byte at `hostAddr` one cycle later. `activeProfile` holds the profile of the last accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host buffer write enable |
| hostAddr | input | 9 | Host buffer byte address |
| hostWData | input | 8 | Host write data |
| hostRData | output | 8 | Buffer byte at last cycle's address |
| cmdWe | input | 1 | Command strobe |
| cmdCode | input | 4 | 0 no-op, 1 start now, 2 start on trigger, 3 halt, 4 flush |
| cmdProfile | input | 4 | Timing profile for a start |
| cmdSelect | input | 3 | Chip-select line for a start |
| extTrig | input | 1 | External start trigger |
| bitTick | input | 1 | Bit-clock enable, one bit position per pulse |
| csPolarity | input | 8 | Active level of each chip-select line |
| prependCnt | input | 4 | Number of prepend bytes |
| dualWrEn | input | 1 | Allow dual-line writes |
| dualWrStart | input | 4 | First byte index of dual writes |
| dualRdEn | input | 1 | Allow dual-line reads |
| dualRdStart | input | 4 | First byte index of dual reads |
| sdi | input | 2 | Serial data in |
| sdo | output | 2 | Serial data out |
| sdoEn | output | 2 | Output enables for `sdo` |
| csLines | output | 8 | Chip-select lines |
| busy | output | 1 | Engine active |
| done | output | 1 | Command-done pulse |
| ctrlInvalid | output | 1 | Start rejected while busy |
| activeProfile | output | 4 | Profile of the accepted start |

## Verification
A start command takes effect on its clock edge, so `busy`, `activeProfile` and the chip selects are sampled at the next falling edge. The first `sdo` bit is also valid then, because the first byte loads on that same edge. Each tick shifts on the rising edge, so the next bit is sampled half a cycle after the tick is removed. After the last tick of the last byte, `done` is expected at the next falling edge and `busy` low one cycle later. Halt expects `busy` low straight after the boundary tick, flush one cycle after its command, and buffer reads are sampled one cycle after the address is presented.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  localparam int BUF_AW = 9;
  localparam int HDR_CNT_W = 11;
  localparam int PRE_W = 4;

  localparam logic [3:0] CMD_GO    = 4'd1;
  localparam logic [3:0] CMD_TRIG  = 4'd2;
  localparam logic [3:0] CMD_HALT  = 4'd3;
  localparam logic [3:0] CMD_FLUSH = 4'd4;

  localparam logic [2:0] OP_SLEEP = 3'd0;
  localparam logic [2:0] OP_RW    = 3'd1;
  localparam logic [2:0] OP_WR    = 3'd2;
  localparam logic [2:0] OP_RD    = 3'd3;

  typedef enum logic [2:0] {ST_IDLE, ST_ARMED, ST_RUN, ST_SLEEP, ST_FIN} seqState_t;

  typedef struct packed {
    logic              loadTx;
    logic              fillOnes;
    logic [BUF_AW-1:0] txAddr;
    logic              shiftOne;
    logic              shiftTwo;
    logic              storeRx;
    logic [BUF_AW-1:0] rxAddr;
    logic              dualMode;
  } seqStrobe_t;
endpackage

// File: rtl/spiseq_datapath.sv
module spiseq_datapath
  import spiseq_pkg::*;
#(
  parameter int BUF_BYTES = 1 << BUF_AW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWe,
  input  logic [BUF_AW-1:0]    hostAddr,
  input  logic [7:0]           hostWData,
  output logic [7:0]           hostRData,
  input  logic                 engineBusy,
  input  seqStrobe_t           strb,
  input  logic [1:0]           sdi,
  output logic [1:0]           sdo,
  output logic [2:0]           hdrOp,
  output logic                 hdrMulti,
  output logic [HDR_CNT_W-1:0] hdrCnt
);
  logic [7:0] mem [BUF_BYTES];
  logic [7:0] shReg;
  logic [7:0] shNext;

  assign hdrOp    = mem[0][7:5];
  assign hdrMulti = mem[0][3];
  assign hdrCnt   = {mem[0][2:0], mem[1]};

  always_comb begin
    if (strb.shiftTwo) shNext = {shReg[5:0], sdi[1], sdi[0]};
    else               shNext = {shReg[6:0], sdi[0]};
  end

  // received bytes take priority; the host may only write while idle
  always_ff @(posedge clk) begin
    if (strb.storeRx)                 mem[strb.rxAddr] <= shNext;
    else if (hostWe && !engineBusy)   mem[hostAddr]    <= hostWData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRData <= '0;
      shReg     <= '0;
    end else begin
      hostRData <= mem[hostAddr];
      if (strb.loadTx)                        shReg <= strb.fillOnes ? 8'hFF : mem[strb.txAddr];
      else if (strb.shiftOne || strb.shiftTwo) shReg <= shNext;
    end
  end

  assign sdo = strb.dualMode ? shReg[7:6] : {1'b0, shReg[7]};

  a_r13_store_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeRx |-> engineBusy);
  a_r3_one_shift_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.shiftOne && strb.shiftTwo));
endmodule

// File: rtl/spiseq_ctrl.sv
module spiseq_ctrl
  import spiseq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int PROF_W = 4,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int IDX_W = HDR_CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdWe,
  input  logic [3:0]           cmdCode,
  input  logic [PROF_W-1:0]    cmdProfile,
  input  logic [CS_W-1:0]      cmdSelect,
  input  logic                 extTrig,
  input  logic                 bitTick,
  input  logic [2:0]           hdrOp,
  input  logic                 hdrMulti,
  input  logic [HDR_CNT_W-1:0] hdrCnt,
  input  logic [PRE_W-1:0]     prependCnt,
  input  logic                 dualWrEn,
  input  logic [PRE_W-1:0]     dualWrStart,
  input  logic                 dualRdEn,
  input  logic [PRE_W-1:0]     dualRdStart,
  input  logic [NUM_CS-1:0]    csPolarity,
  output seqStrobe_t           strb,
  output logic                 busy,
  output logic                 done,
  output logic                 ctrlInvalid,
  output logic [NUM_CS-1:0]    csLines,
  output logic [1:0]           sdoEn,
  output logic [PROF_W-1:0]    activeProfile
);
  seqState_t state;
  logic [2:0]       opcode;
  logic             multi;
  logic [IDX_W-1:0] total, byteIdx, txIdx, hdrTotal, preIdx;
  logic [2:0]       bitCnt;
  logic             haltPend;
  logic [CS_W-1:0]  csSel;
  logic goNow, armReq, startReq, launch, haltReq, flushReq;
  logic hdrIsData, inPayload, dualNow, running, byteEnd, lastByte;
  logic [2:0] curOp;
  logic [NUM_CS-1:0] csActive;
  seqState_t launchState;

  assign goNow    = cmdWe && cmdCode == CMD_GO;
  assign armReq   = cmdWe && cmdCode == CMD_TRIG;
  assign startReq = goNow || armReq;
  assign haltReq  = cmdWe && cmdCode == CMD_HALT;
  assign flushReq = cmdWe && cmdCode == CMD_FLUSH;
  assign launch   = (state == ST_IDLE && goNow) || (state == ST_ARMED && extTrig);

  assign preIdx    = IDX_W'(prependCnt);
  assign hdrIsData = hdrOp == OP_RW || hdrOp == OP_WR || hdrOp == OP_RD;
  assign hdrTotal  = hdrIsData ? IDX_W'(hdrCnt) + preIdx : IDX_W'(hdrCnt);

  always_comb begin
    if (hdrIsData && hdrTotal != '0)              launchState = ST_RUN;
    else if (hdrOp == OP_SLEEP && hdrTotal != '0) launchState = ST_SLEEP;
    else                                          launchState = ST_FIN;
  end

  assign running   = state == ST_RUN;
  assign inPayload = byteIdx >= preIdx;
  assign dualNow   = multi && inPayload &&
                     ((opcode == OP_WR && dualWrEn && byteIdx >= IDX_W'(dualWrStart)) ||
                      (opcode == OP_RD && dualRdEn && byteIdx >= IDX_W'(dualRdStart)));
  assign byteEnd   = running && bitTick && (dualNow ? bitCnt == 3'd3 : bitCnt == 3'd7);
  assign lastByte  = byteIdx + IDX_W'(1) == total;
  assign curOp     = launch ? hdrOp : opcode;
  assign txIdx     = launch ? '0 : byteIdx + IDX_W'(1);

  always_comb begin
    strb          = '0;
    strb.dualMode = running && dualNow;
    strb.shiftOne = running && bitTick && !dualNow;
    strb.shiftTwo = running && bitTick && dualNow;
    strb.storeRx  = byteEnd && inPayload && (opcode == OP_RW || opcode == OP_RD);
    strb.rxAddr   = BUF_AW'(byteIdx - preIdx);
    strb.loadTx   = (launch && hdrIsData) || (byteEnd && !lastByte);
    strb.txAddr   = BUF_AW'(txIdx + IDX_W'(2));
    strb.fillOnes = curOp == OP_RD && txIdx >= preIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      opcode        <= '0;
      multi         <= 1'b0;
      total         <= '0;
      byteIdx       <= '0;
      bitCnt        <= '0;
      haltPend      <= 1'b0;
      csSel         <= '0;
      activeProfile <= '0;
      ctrlInvalid   <= 1'b0;
    end else begin
      if (startReq) ctrlInvalid <= (state != ST_IDLE);
      if (startReq && state == ST_IDLE) begin
        csSel         <= cmdSelect;
        activeProfile <= cmdProfile;
      end
      if (launch) begin
        opcode   <= hdrOp;
        multi    <= hdrMulti;
        total    <= hdrTotal;
        byteIdx  <= '0;
        bitCnt   <= '0;
        haltPend <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (goNow)       state <= launchState;
          else if (armReq) state <= ST_ARMED;
        end
        ST_ARMED: begin
          if (flushReq || haltReq) state <= ST_IDLE;
          else if (extTrig)        state <= launchState;
        end
        ST_RUN: begin
          if (flushReq) state <= ST_IDLE;
          else begin
            if (haltReq) haltPend <= 1'b1;
            if (byteEnd) begin
              bitCnt  <= '0;
              byteIdx <= byteIdx + IDX_W'(1);
              if (lastByte)                  state <= ST_FIN;
              else if (haltPend || haltReq)  state <= ST_IDLE;
            end else if (bitTick) begin
              bitCnt <= bitCnt + 3'd1;
            end
          end
        end
        ST_SLEEP: begin
          if (flushReq || haltReq) state <= ST_IDLE;
          else if (bitTick) begin
            byteIdx <= byteIdx + IDX_W'(1);
            if (lastByte) state <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = state != ST_IDLE;
  assign done = state == ST_FIN;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign csActive[i] = running && csSel == CS_W'(i);
    assign csLines[i]  = csActive[i] ? csPolarity[i] : ~csPolarity[i];
  end

  always_comb begin
    if (!running)     sdoEn = 2'b00;
    else if (dualNow) sdoEn = (opcode == OP_WR) ? 2'b11 : 2'b00;
    else              sdoEn = 2'b01;
  end

  a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r8_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csActive));
  a_r9_start_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && busy) |=> ctrlInvalid);
  a_r10_flush_drops_busy: assert property (@(posedge clk) disable iff (!rstN)
    (flushReq && busy) |=> !busy);
  a_r9_profile_kept: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && busy) |=> $stable(activeProfile));
endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
  import spiseq_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int PROF_W = 4,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [BUF_AW-1:0] hostAddr,
  input  logic [7:0]        hostWData,
  output logic [7:0]        hostRData,
  input  logic              cmdWe,
  input  logic [3:0]        cmdCode,
  input  logic [PROF_W-1:0] cmdProfile,
  input  logic [CS_W-1:0]   cmdSelect,
  input  logic              extTrig,
  input  logic              bitTick,
  input  logic [NUM_CS-1:0] csPolarity,
  input  logic [PRE_W-1:0]  prependCnt,
  input  logic              dualWrEn,
  input  logic [PRE_W-1:0]  dualWrStart,
  input  logic              dualRdEn,
  input  logic [PRE_W-1:0]  dualRdStart,
  input  logic [1:0]        sdi,
  output logic [1:0]        sdo,
  output logic [1:0]        sdoEn,
  output logic [NUM_CS-1:0] csLines,
  output logic              busy,
  output logic              done,
  output logic              ctrlInvalid,
  output logic [PROF_W-1:0] activeProfile
);
  seqStrobe_t           strb;
  logic [2:0]           hdrOp;
  logic                 hdrMulti;
  logic [HDR_CNT_W-1:0] hdrCnt;

  spiseq_datapath u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData), .engineBusy(busy),
    .strb(strb), .sdi(sdi), .sdo(sdo),
    .hdrOp(hdrOp), .hdrMulti(hdrMulti), .hdrCnt(hdrCnt)
  );

  spiseq_ctrl #(.NUM_CS(NUM_CS), .PROF_W(PROF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdCode(cmdCode),
    .cmdProfile(cmdProfile), .cmdSelect(cmdSelect), .extTrig(extTrig),
    .bitTick(bitTick), .hdrOp(hdrOp), .hdrMulti(hdrMulti), .hdrCnt(hdrCnt),
    .prependCnt(prependCnt), .dualWrEn(dualWrEn), .dualWrStart(dualWrStart),
    .dualRdEn(dualRdEn), .dualRdStart(dualRdStart), .csPolarity(csPolarity),
    .strb(strb), .busy(busy), .done(done), .ctrlInvalid(ctrlInvalid),
    .csLines(csLines), .sdoEn(sdoEn), .activeProfile(activeProfile)
  );
endmodule

// File: tb/spi_cmd_sequencer_tb.sv
module spi_cmd_sequencer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0;
  logic [8:0] hostAddr = '0;
  logic [7:0] hostWData = '0;
  logic [7:0] hostRData;
  logic cmdWe = 1'b0;
  logic [3:0] cmdCode = '0;
  logic [3:0] cmdProfile = '0;
  logic [2:0] cmdSelect = '0;
  logic extTrig = 1'b0, bitTick = 1'b0;
  logic [7:0] csPolarity = 8'hA5;
  logic [3:0] prependCnt = '0, dualWrStart = '0, dualRdStart = '0;
  logic dualWrEn = 1'b0, dualRdEn = 1'b0;
  logic [1:0] sdi = '0;
  logic [1:0] sdo, sdoEn;
  logic [7:0] csLines;
  logic busy, done, ctrlInvalid;
  logic [3:0] activeProfile;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [7:0] shadow [512];

  spi_cmd_sequencer u_dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWData(hostWData), .hostRData(hostRData), .cmdWe(cmdWe), .cmdCode(cmdCode),
    .cmdProfile(cmdProfile), .cmdSelect(cmdSelect), .extTrig(extTrig),
    .bitTick(bitTick), .csPolarity(csPolarity), .prependCnt(prependCnt),
    .dualWrEn(dualWrEn), .dualWrStart(dualWrStart), .dualRdEn(dualRdEn),
    .dualRdStart(dualRdStart), .sdi(sdi), .sdo(sdo), .sdoEn(sdoEn),
    .csLines(csLines), .busy(busy), .done(done), .ctrlInvalid(ctrlInvalid),
    .activeProfile(activeProfile)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      nFails = nFails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] csIdle();
    return ~csPolarity;
  endfunction

  function automatic logic [7:0] csSel(input int cs);
    logic [7:0] v;
    v = ~csPolarity;
    v[cs] = csPolarity[cs];
    return v;
  endfunction

  function automatic logic [7:0] rxPat(input int seed, input int k);
    return 8'((seed * 13 + k * 29 + 5) & 255);
  endfunction

  task automatic hostWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 9'(a); hostWData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input int a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = 9'(a);
    @(negedge clk);
    d = hostRData;
  endtask

  task automatic sendCmd(input logic [3:0] code, input logic [3:0] prof, input int cs);
    @(negedge clk);
    cmdWe = 1'b1; cmdCode = code; cmdProfile = prof; cmdSelect = 3'(cs);
    @(negedge clk);
    cmdWe = 1'b0;
  endtask

  task automatic tick();
    bitTick = 1'b1;
    @(negedge clk);
    bitTick = 1'b0;
  endtask

  // header and buffer contents for one transaction (R1)
  task automatic setup(input int op, input bit multi, input int cnt, input int p, input int seed);
    logic [15:0] hdr;
    prependCnt = 4'(p);
    hdr = {3'(op), 1'b0, multi, 11'(cnt)};
    hostWrite(0, hdr[15:8]); shadow[0] = hdr[15:8];
    hostWrite(1, hdr[7:0]);  shadow[1] = hdr[7:0];
    for (int a = 2; a < 2 + p + cnt; a++) begin
      logic [7:0] d;
      d = 8'((a * 37 + seed * 11 + 3) & 255);
      hostWrite(a, d);
      shadow[a] = d;
    end
  endtask

  task automatic runBytes(input int op, input bit multi, input int cnt, input int p,
                          input int cs, input int seed, input int stopAfter);
    for (int k = 0; k < p + cnt && k < stopAfter; k++) begin
      bit dual;
      int nt;
      logic [7:0] expTx, rxB, obs;
      string tag;
      dual = multi && k >= p &&
             ((op == 2 && dualWrEn && k >= int'(dualWrStart)) ||
              (op == 3 && dualRdEn && k >= int'(dualRdStart)));
      nt = dual ? 4 : 8;
      expTx = (op == 3 && k >= p) ? 8'hFF : shadow[2 + k];
      rxB = rxPat(seed, k);
      obs = '0;
      tag = dual ? "R7" : (k < p ? "R4" : (op == 3 ? "R5" : (op == 1 ? "R6" : "R3")));
      check(csLines, csSel(cs), "R8 select active");
      check(sdoEn, dual ? (op == 2 ? 2'b11 : 2'b00) : 2'b01, {tag, " output enable"});
      for (int t = 0; t < nt; t++) begin
        if (dual) begin
          obs = {obs[5:0], sdo};
          sdi = {rxB[7 - 2 * t], rxB[6 - 2 * t]};
        end else begin
          obs = {obs[6:0], sdo[0]};
          sdi = {1'b0, rxB[7 - t]};
        end
        tick();
      end
      if (!(dual && op == 3)) check(obs, expTx, {tag, " tx byte"});
      if ((op == 1 || op == 3) && k >= p) shadow[k - p] = rxB;
    end
  endtask

  task automatic endCheck(input string tag);
    check(done, 1'b1, {tag, " done after last tick"});
    check(busy, 1'b1, "R2 busy during done");
    @(negedge clk);
    check(busy, 1'b0, "R2 busy low after done");
    check(done, 1'b0, "R2 done one cycle");
    check(csLines, csIdle(), "R8 idle selects");
  endtask

  task automatic readback(input int n, input string tag);
    for (int a = 0; a < n; a++) begin
      logic [7:0] d;
      hostRead(a, d);
      check(d, shadow[a], tag);
    end
  endtask

  task automatic fullXfer(input int op, input bit multi, input int cnt, input int p,
                          input int cs, input int seed);
    logic [3:0] prof;
    prof = 4'((seed + 3) & 15);
    setup(op, multi, cnt, p, seed);
    sendCmd(4'd1, prof, cs);
    check(busy, 1'b1, "R2 busy after start");
    check(activeProfile, prof, "R13 profile latched");
    check(ctrlInvalid, 1'b0, "R9 cleared by accepted start");
    runBytes(op, multi, cnt, p, cs, seed, 1000);
    endCheck("R2");
    readback(2 + p + cnt, op == 2 ? "R13 buffer intact" : "R5 rx stored from 0");
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check(busy, 1'b0, "R2 reset busy");
    check(done, 1'b0, "R2 reset done");
    check(ctrlInvalid, 1'b0, "R9 reset flag");
    check(csLines, csIdle(), "R8 reset selects");
    rstN = 1'b1;
    @(negedge clk);

    // sweep of opcodes, prepend lengths and payload lengths, single line
    for (int op = 1; op <= 3; op++)
      for (int p = 0; p <= 3; p++)
        for (int cnt = 1; cnt <= 3; cnt++)
          fullXfer(op, 1'b0, cnt, p, (p * 3 + cnt + op) % 8, op * 16 + p * 4 + cnt);

    // prepend at its maximum
    fullXfer(1, 1'b0, 2, 15, 7, 99);

    // dual write from a byte offset past the prepend
    dualWrEn = 1'b1; dualWrStart = 4'd2;
    fullXfer(2, 1'b1, 3, 1, 4, 5);
    // dual flag ignored inside the prepend even when the offset is 0
    dualWrStart = 4'd0;
    fullXfer(2, 1'b1, 2, 2, 3, 6);
    dualWrEn = 1'b0;
    // dual requested in header but not enabled: stays single
    fullXfer(2, 1'b1, 2, 0, 2, 7);
    // dual read
    dualRdEn = 1'b1; dualRdStart = 4'd1;
    fullXfer(3, 1'b1, 3, 1, 6, 8);
    dualRdEn = 1'b0;

    // R9 / R13: start while busy and host write while busy
    setup(2, 1'b0, 2, 0, 20);
    hostWrite(400, 8'h3C); shadow[400] = 8'h3C;
    sendCmd(4'd1, 4'd9, 1);
    sendCmd(4'd1, 4'd2, 5);
    check(ctrlInvalid, 1'b1, "R9 flag on busy start");
    check(activeProfile, 4'd9, "R9 profile unchanged");
    hostWrite(400, 8'hC3);
    runBytes(2, 1'b0, 2, 0, 1, 20, 1000);
    endCheck("R9");
    hostRead(400, d);
    check(d, 8'h3C, "R13 busy write ignored");
    fullXfer(2, 1'b0, 1, 0, 0, 21);

    // R10 halt at byte boundary
    setup(2, 1'b0, 3, 0, 30);
    sendCmd(4'd1, 4'd1, 2);
    for (int t = 0; t < 3; t++) tick();
    sendCmd(4'd3, 4'd0, 0);
    check(busy, 1'b1, "R10 halt waits for boundary");
    for (int t = 0; t < 4; t++) tick();
    check(busy, 1'b1, "R10 still in byte");
    tick();
    check(busy, 1'b0, "R10 halted at boundary");
    check(done, 1'b0, "R10 no done on halt");
    check(csLines, csIdle(), "R10 selects released");

    // R10 flush
    setup(2, 1'b0, 3, 0, 31);
    sendCmd(4'd1, 4'd1, 2);
    tick(); tick();
    sendCmd(4'd4, 4'd0, 0);
    check(busy, 1'b0, "R10 flush immediate");
    check(sdoEn, 2'b00, "R10 flush releases data");
    @(negedge clk);
    check(done, 1'b0, "R10 no done on flush");

    // R11 external trigger
    setup(1, 1'b0, 2, 1, 40);
    sendCmd(4'd2, 4'd6, 3);
    check(busy, 1'b1, "R11 armed busy");
    check(csLines, csIdle(), "R11 armed selects idle");
    tick();
    check(sdoEn, 2'b00, "R11 tick ignored while armed");
    @(negedge clk);
    extTrig = 1'b1;
    @(negedge clk);
    extTrig = 1'b0;
    check(activeProfile, 4'd6, "R11 profile");
    runBytes(1, 1'b0, 2, 1, 3, 40, 1000);
    endCheck("R11");
    readback(5, "R11 rx stored");

    // R12 sleep and raise interrupt
    setup(0, 1'b0, 3, 0, 50);
    sendCmd(4'd1, 4'd0, 4);
    check(busy, 1'b1, "R12 sleep busy");
    check(csLines, csIdle(), "R12 sleep no select");
    tick(); tick();
    check(done, 1'b0, "R12 sleep not yet done");
    tick();
    endCheck("R12 sleep");
    setup(4, 1'b0, 0, 0, 51);
    sendCmd(4'd1, 4'd0, 4);
    endCheck("R12 irq");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule